// File: doc/BRIEF.md
# Wake-up Frame Detector

This block watches a received Ethernet byte stream and recognises wake-up frames. Each byte arrives with a valid qualifier, and the first and last bytes of a frame are marked by start and end strobes. A qualifying frame has a payload that contains a run of at least six 0xFF bytes followed directly by sixteen back-to-back copies of the programmed 48-bit station address. The search for that run starts after the twelve address bytes of the header and may begin at any later byte offset.

The destination address of the frame must equal the station address. The exception is when accept-any-destination is in force: then unicast, multicast and broadcast destinations all pass. That condition is the OR of a local control bit and an external accept input.

A five-bit control/status register holds the mode, enable, interrupt-enable, interrupt-status and accept bits. Detection is armed only while the mode bit is set and either the enable bit is set or the external power-good input is high. A qualifying frame seen while detection is armed latches the status bit. The interrupt output follows that status bit, gated by its enable bit and by a global interrupt-enable input.

Top module: `wake_frame_detector`

## Requirements
- R1: Detection is armed only when the mode bit (bit 0) is 1 and either powerGood is high or the enable bit (bit 1) is 1. A qualifying frame seen while disarmed leaves the status bit (bit 3) at 0.
- R2: With the local accept bit (bit 4) and extAccept both 0, a frame whose first six bytes differ from the station address never sets the status bit. The station address is sent most significant byte first.
- R3: With the local accept bit or extAccept at 1, a frame with any destination (another unicast address or all-ones broadcast) still sets the status bit if its payload qualifies.
- R4: The payload qualifies when, at byte 12 or later, it holds at least six consecutive 0xFF bytes followed at once by sixteen consecutive copies of the station address. Junk bytes and broken 0xFF runs before the sequence only restart the search. Five 0xFF bytes are not enough.
- R5: The full sequence must be complete by the end-of-frame byte. Fifteen copies do not qualify. Progress made in one frame never counts towards the next frame.
- R6: The status bit reads 1 from the second rising clock edge after the end-of-frame byte is sampled.
- R7: irqOut is 1 exactly when the status bit, the interrupt-enable bit (bit 2) and globalIntEn are all 1.
- R8: Writing 1 to bit 3 clears the status bit, and writing 0 to it has no effect. When a frame sets the status bit in the same cycle as a clearing write, the status bit ends up 1.
- R9: A stopReq pulse clears the status bit and leaves the mode, enable, interrupt-enable and accept bits unchanged.
- R10: Hard reset (rstN low) and softReset both clear all five bits, so the register reads 0 and irqOut is 0.
- R11: The register sits at index 0 and reads back {accept, status, intEnable, enable, mode} in bits 4 down to 0. Any other index reads 0, and writes to other indices change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hard reset |
| softReset | input | 1 | Synchronous soft reset, clears all register bits and the scan state |
| stopReq | input | 1 | Stop control, clears only the status bit |
| powerGood | input | 1 | External power-good input, arms detection together with the mode bit |
| extAccept | input | 1 | Accept-any-destination bit held outside this register |
| globalIntEn | input | 1 | Global interrupt enable |
| stationAddr | input | 48 | Programmed station address, byte 0 in bits 47:40 |
| rxValid | input | 1 | Byte valid |
| rxSof | input | 1 | First byte of frame |
| rxEof | input | 1 | Last byte of frame |
| rxData | input | 8 | Received byte |
| regWe | input | 1 | Register write strobe |
| regIdx | input | 4 | Register index for read and write |
| regWdata | input | 5 | Register write data |
| regRdata | output | 5 | Register read data, combinational from regIdx |
| irqOut | output | 1 | Interrupt output |

## Verification
The end-of-frame byte is sampled at one edge and registered as a hit. The status bit and irqOut change at the next edge, so every frame scenario waits two falling edges after the strobe is dropped before it reads the register. A register write takes effect at the edge after the falling edge that drives it. Read data is combinational, so each read samples one nanosecond after its index is set on a falling edge. The set-versus-clear case places its clearing write on the falling edge just before the edge that loads the registered hit, so both events land on the same edge.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int CTRL_BITS = 5;
  localparam int BIT_MODE  = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_IE    = 2;
  localparam int BIT_STAT  = 3;
  localparam int BIT_ACC   = 4;

  typedef enum logic [1:0] {SCAN_SYNC, SCAN_ADDR, SCAN_DONE} scanPhaseT;

  typedef struct packed {
    logic acceptAll;
    logic flush;
  } ctlStrobeT;
endpackage

// File: rtl/wake_scan.sv
module wake_scan
  import wake_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HDR_BYTES  = 12,
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobeT               ctl,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    rxValid,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic [7:0]              rxData,
  output logic                    frameHit
);
  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int AW = $clog2(ADDR_BYTES);
  localparam int HW = $clog2(HDR_BYTES + 1);
  localparam int FW = $clog2(SYNC_LEN + 1);
  localparam int CW = $clog2(COPIES);
  localparam logic [AW-1:0] A_LAST = AW'(ADDR_BYTES - 1);
  localparam logic [FW-1:0] F_LAST = FW'(SYNC_LEN - 1);
  localparam logic [CW-1:0] C_LAST = CW'(COPIES - 1);
  localparam logic [HW-1:0] H_END  = HW'(HDR_BYTES);
  localparam logic [HW-1:0] A_END  = HW'(ADDR_BYTES);

  logic [7:0] addrB [ADDR_BYTES];
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
    assign addrB[g] = stationAddr[ADDR_W-1-8*g -: 8];
  end

  scanPhaseT     phase, phaseN;
  logic [HW-1:0] hdrCnt, hdrN, idx;
  logic [FW-1:0] ffCnt, ffN;
  logic [AW-1:0] aIdx, aN;
  logic [CW-1:0] copyCnt, cN;
  logic          destEq, destN, inFrame, inFrameN, take, hitN;

  always_comb begin
    take     = rxValid && (rxSof || inFrame);
    idx      = rxSof ? '0 : hdrCnt;
    phaseN   = rxSof ? SCAN_SYNC : phase;
    ffN      = rxSof ? '0 : ffCnt;
    aN       = rxSof ? '0 : aIdx;
    cN       = rxSof ? '0 : copyCnt;
    destN    = rxSof ? 1'b1 : destEq;
    hdrN     = rxSof ? '0 : hdrCnt;
    inFrameN = inFrame;
    if (take) begin
      inFrameN = !rxEof;
      if (idx < H_END) begin
        hdrN = idx + 1'b1;
        if (idx < A_END && rxData != addrB[idx[AW-1:0]]) destN = 1'b0;
      end else begin
        unique case (phaseN)
          SCAN_SYNC: begin
            if (rxData == 8'hFF) begin
              if (ffN == F_LAST) begin
                phaseN = SCAN_ADDR;
                aN     = '0;
                cN     = '0;
              end else begin
                ffN = ffN + 1'b1;
              end
            end else begin
              ffN = '0;
            end
          end
          SCAN_ADDR: begin
            if (rxData == addrB[aN]) begin
              if (aN == A_LAST) begin
                aN = '0;
                if (cN == C_LAST) phaseN = SCAN_DONE;
                else cN = cN + 1'b1;
              end else begin
                aN = aN + 1'b1;
              end
            end else if (!(rxData == 8'hFF && aN == '0 && cN == '0)) begin
              phaseN = SCAN_SYNC;
              ffN    = (rxData == 8'hFF) ? FW'(1) : '0;
            end
          end
          default: ;
        endcase
      end
    end
    hitN = take && rxEof && phaseN == SCAN_DONE && (destN || ctl.acceptAll);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= SCAN_SYNC; hdrCnt <= '0; ffCnt <= '0; aIdx <= '0;
      copyCnt <= '0; destEq <= 1'b0; inFrame <= 1'b0; frameHit <= 1'b0;
    end else if (ctl.flush) begin
      phase <= SCAN_SYNC; hdrCnt <= '0; ffCnt <= '0; aIdx <= '0;
      copyCnt <= '0; destEq <= 1'b0; inFrame <= 1'b0; frameHit <= 1'b0;
    end else begin
      phase <= phaseN; hdrCnt <= hdrN; ffCnt <= ffN; aIdx <= aN;
      copyCnt <= cN; destEq <= destN; inFrame <= inFrameN; frameHit <= hitN;
    end
  end

  AST_HIT_ON_EOF: assert property (@(posedge clk) disable iff (!rstN)
    frameHit |-> $past(rxValid && rxEof)); // R5

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (phase == SCAN_DONE && inFrame && !rxSof && !ctl.flush) |=> phase == SCAN_DONE); // R4
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int CTRL_IDX = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 softReset,
  input  logic                 stopReq,
  input  logic                 powerGood,
  input  logic                 extAccept,
  input  logic                 globalIntEn,
  input  logic                 regWe,
  input  logic [IDX_W-1:0]     regIdx,
  input  logic [CTRL_BITS-1:0] regWdata,
  output logic [CTRL_BITS-1:0] regRdata,
  input  logic                 frameHit,
  output ctlStrobeT            ctl,
  output logic                 irqOut
);
  localparam logic [IDX_W-1:0] SEL = IDX_W'(CTRL_IDX);

  logic modeBit, enBit, ieBit, statBit, accBit, wSel, armed;

  assign wSel  = regWe && regIdx == SEL;
  assign armed = modeBit && (powerGood || enBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeBit <= 1'b0; enBit <= 1'b0; ieBit <= 1'b0; accBit <= 1'b0;
    end else if (softReset) begin
      modeBit <= 1'b0; enBit <= 1'b0; ieBit <= 1'b0; accBit <= 1'b0;
    end else if (wSel) begin
      modeBit <= regWdata[BIT_MODE];
      enBit   <= regWdata[BIT_EN];
      ieBit   <= regWdata[BIT_IE];
      accBit  <= regWdata[BIT_ACC];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          statBit <= 1'b0;
    else if (softReset || stopReq)      statBit <= 1'b0;
    else if (frameHit && armed)         statBit <= 1'b1;
    else if (wSel && regWdata[BIT_STAT]) statBit <= 1'b0;
  end

  always_comb begin
    regRdata = '0;
    if (regIdx == SEL) begin
      regRdata[BIT_MODE] = modeBit;
      regRdata[BIT_EN]   = enBit;
      regRdata[BIT_IE]   = ieBit;
      regRdata[BIT_STAT] = statBit;
      regRdata[BIT_ACC]  = accBit;
    end
  end

  assign ctl.acceptAll = accBit || extAccept;
  assign ctl.flush     = softReset;
  assign irqOut        = statBit && ieBit && globalIntEn;

  AST_ROSE_NEEDS_ARMED_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statBit) |-> $past(frameHit && armed)); // R1

  AST_HIT_SETS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (frameHit && armed && !softReset && !stopReq) |=> statBit); // R6

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (statBit && wSel && !regWdata[BIT_STAT] && !softReset && !stopReq) |=> statBit); // R8

  AST_STOP_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !softReset && !wSel) |=> ($stable({modeBit, enBit, ieBit, accBit}) && !statBit)); // R9

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> !(modeBit || enBit || ieBit || accBit || statBit || irqOut)); // R10
endmodule

// File: rtl/wake_frame_detector.sv
module wake_frame_detector
  import wake_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HDR_BYTES  = 12,
  parameter int SYNC_LEN   = 6,
  parameter int COPIES     = 16,
  parameter int IDX_W      = 4,
  parameter int CTRL_IDX   = 0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    softReset,
  input  logic                    stopReq,
  input  logic                    powerGood,
  input  logic                    extAccept,
  input  logic                    globalIntEn,
  input  logic [8*ADDR_BYTES-1:0] stationAddr,
  input  logic                    rxValid,
  input  logic                    rxSof,
  input  logic                    rxEof,
  input  logic [7:0]              rxData,
  input  logic                    regWe,
  input  logic [IDX_W-1:0]        regIdx,
  input  logic [CTRL_BITS-1:0]    regWdata,
  output logic [CTRL_BITS-1:0]    regRdata,
  output logic                    irqOut
);
  ctlStrobeT ctl;
  logic      frameHit;

  wake_ctrl #(.IDX_W(IDX_W), .CTRL_IDX(CTRL_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .softReset(softReset), .stopReq(stopReq),
    .powerGood(powerGood), .extAccept(extAccept), .globalIntEn(globalIntEn),
    .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata), .regRdata(regRdata),
    .frameHit(frameHit), .ctl(ctl), .irqOut(irqOut)
  );

  wake_scan #(.ADDR_BYTES(ADDR_BYTES), .HDR_BYTES(HDR_BYTES),
              .SYNC_LEN(SYNC_LEN), .COPIES(COPIES)) u_scan (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stationAddr(stationAddr),
    .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof), .rxData(rxData),
    .frameHit(frameHit)
  );
endmodule

// File: tb/wake_frame_detector_bench.sv
module wake_frame_detector_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, softReset, stopReq, powerGood, extAccept, globalIntEn;
  logic rxValid, rxSof, rxEof, regWe;
  logic [7:0]  rxData;
  logic [3:0]  regIdx;
  logic [4:0]  regWdata, regRdata;
  logic        irqOut;
  localparam logic [47:0] STA = 48'h0A1B2C3D4E5F;

  wake_frame_detector u_wake_frame_detector (
    .clk(clk), .rstN(rstN), .softReset(softReset), .stopReq(stopReq),
    .powerGood(powerGood), .extAccept(extAccept), .globalIntEn(globalIntEn),
    .stationAddr(STA), .rxValid(rxValid), .rxSof(rxSof), .rxEof(rxEof),
    .rxData(rxData), .regWe(regWe), .regIdx(regIdx), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  logic [7:0] frameBuf [0:159];
  int frameLen;

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    frameBuf[frameLen] = b;
    frameLen++;
  endtask

  task automatic build(input logic [47:0] dst, input int syncN, input int copies, input bit junk);
    frameLen = 0;
    for (int i = 0; i < 6; i++) push(dst[47-8*i -: 8]);
    for (int i = 0; i < 6; i++) push(8'h02 + 8'(i));
    push(8'h08); push(8'h42);
    if (junk) begin push(8'h11); push(8'hFF); push(8'hFF); push(8'hFF); push(8'h33); end
    for (int i = 0; i < syncN; i++) push(8'hFF);
    for (int c = 0; c < copies; c++)
      for (int i = 0; i < 6; i++) push(STA[47-8*i -: 8]);
    push(8'hAA); push(8'hAA);
  endtask

  task automatic sendFrame(input bit clearAtEnd, input logic [4:0] cfg);
    for (int i = 0; i < frameLen; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxSof = (i == 0); rxEof = (i == frameLen - 1); rxData = frameBuf[i];
    end
    @(negedge clk);
    rxValid = 1'b0; rxSof = 1'b0; rxEof = 1'b0;
    if (clearAtEnd) begin regWe = 1'b1; regIdx = 4'd0; regWdata = cfg | 5'h08; end
    @(negedge clk);
    regWe = 1'b0;
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [3:0] idx, input logic [4:0] data);
    @(negedge clk);
    regWe = 1'b1; regIdx = idx; regWdata = data;
    @(negedge clk);
    regWe = 1'b0; regIdx = 4'd0;
  endtask

  task automatic readCheck(input string req, input string what, input logic [3:0] idx, input logic [4:0] exp);
    @(negedge clk);
    regIdx = idx;
    #1;
    check(req, what, {3'b0, regRdata}, {3'b0, exp});
    regIdx = 4'd0;
  endtask

  task automatic irqCheck(input string req, input logic exp);
    #1;
    check(req, "irqOut", {7'b0, irqOut}, {7'b0, exp});
  endtask

  task automatic testReset();
    readCheck("R10", "register after hard reset", 4'd0, 5'h00);
    irqCheck("R10", 1'b0);
  endtask

  task automatic testRegAccess();
    writeReg(4'd0, 5'h17);
    readCheck("R11", "readback bits", 4'd0, 5'h17);
    readCheck("R11", "other index read", 4'd3, 5'h00);
    writeReg(4'd2, 5'h00);
    readCheck("R11", "write to other index ignored", 4'd0, 5'h17);
    writeReg(4'd0, 5'h00);
  endtask

  task automatic testModeGate();
    writeReg(4'd0, 5'h01);
    powerGood = 1'b0;
    build(STA, 6, 16, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R1", "mode only, no power-good", 4'd0, 5'h01);
    powerGood = 1'b1;
    sendFrame(1'b0, 5'h00);
    readCheck("R1", "mode with power-good", 4'd0, 5'h09);
    writeReg(4'd0, 5'h09);
    powerGood = 1'b0;
    writeReg(4'd0, 5'h02);
    sendFrame(1'b0, 5'h00);
    readCheck("R1", "enable without mode", 4'd0, 5'h02);
  endtask

  task automatic testUnicast();
    writeReg(4'd0, 5'h07);
    globalIntEn = 1'b1;
    build(STA, 6, 16, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R6", "status after matching unicast", 4'd0, 5'h0F);
    irqCheck("R7", 1'b1);
    writeReg(4'd0, 5'h07);
    readCheck("R8", "write 0 to status keeps it", 4'd0, 5'h0F);
    globalIntEn = 1'b0;
    irqCheck("R7", 1'b0);
    globalIntEn = 1'b1;
    writeReg(4'd0, 5'h03);
    readCheck("R7", "int enable off", 4'd0, 5'h0B);
    irqCheck("R7", 1'b0);
    writeReg(4'd0, 5'h0B);
    readCheck("R8", "write 1 clears status", 4'd0, 5'h03);
  endtask

  task automatic testDest();
    writeReg(4'd0, 5'h03);
    build(48'h0A1B2C3D4E60, 6, 16, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R2", "wrong dest, accept off", 4'd0, 5'h03);
    extAccept = 1'b1;
    sendFrame(1'b0, 5'h00);
    readCheck("R3", "wrong dest, external accept", 4'd0, 5'h0B);
    extAccept = 1'b0;
    writeReg(4'd0, 5'h0B);
    writeReg(4'd0, 5'h13);
    build(48'hFFFFFFFFFFFF, 6, 16, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R3", "broadcast dest, local accept", 4'd0, 5'h1B);
    writeReg(4'd0, 5'h1B);
    readCheck("R3", "cleared after broadcast", 4'd0, 5'h13);
    writeReg(4'd0, 5'h03);
  endtask

  task automatic testShort();
    build(STA, 6, 15, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R5", "fifteen copies", 4'd0, 5'h03);
    build(STA, 0, 1, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R5", "no carry-over between frames", 4'd0, 5'h03);
  endtask

  task automatic testRestart();
    build(STA, 7, 16, 1'b1);
    sendFrame(1'b0, 5'h00);
    readCheck("R4", "junk then seven 0xFF", 4'd0, 5'h0B);
    writeReg(4'd0, 5'h0B);
    build(STA, 5, 16, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R4", "only five 0xFF", 4'd0, 5'h03);
  endtask

  task automatic testSetWins();
    build(STA, 6, 16, 1'b0);
    sendFrame(1'b1, 5'h03);
    readCheck("R8", "set beats same-cycle clear", 4'd0, 5'h0B);
    writeReg(4'd0, 5'h0B);
  endtask

  task automatic testStop();
    writeReg(4'd0, 5'h17);
    build(STA, 6, 16, 1'b0);
    sendFrame(1'b0, 5'h00);
    readCheck("R9", "status before stop", 4'd0, 5'h1F);
    @(negedge clk); stopReq = 1'b1;
    @(negedge clk); stopReq = 1'b0;
    readCheck("R9", "stop clears status only", 4'd0, 5'h17);
  endtask

  task automatic testSoft();
    build(STA, 6, 16, 1'b0);
    sendFrame(1'b0, 5'h00);
    @(negedge clk); softReset = 1'b1;
    @(negedge clk); softReset = 1'b0;
    readCheck("R10", "after soft reset", 4'd0, 5'h00);
    irqCheck("R10", 1'b0);
  endtask

  initial begin
    rstN = 1'b0; softReset = 1'b0; stopReq = 1'b0; powerGood = 1'b0;
    extAccept = 1'b0; globalIntEn = 1'b0; rxValid = 1'b0; rxSof = 1'b0;
    rxEof = 1'b0; rxData = 8'h00; regWe = 1'b0; regIdx = 4'd0; regWdata = 5'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegAccess();
    testModeGate();
    testUnicast();
    testDest();
    testShort();
    testRestart();
    testSetWins();
    testStop();
    testSoft();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule